// File: doc/BRIEF.md
# Three-Channel Match-Comparator Timer

This peripheral holds several independent up-counters (three by default), each paired with its own bank of match comparators (three by default). Software starts and stops each counter through a shared enable register and programs the comparator values. It also sets whether comparator 0 folds the count back to zero, which gives a periodic timebase, or whether the counter runs on and wraps at its full width. Each comparator sets a sticky pending bit. One level interrupt per timer is raised while any pending bit of that timer is also enabled.

The live count is not wired straight to the bus. Software writes a request to a capture register, and the count of that cycle is held in a shadow. It is copied to the readable snapshot only after a fixed settling time. While that time runs, a busy flag is shown and further requests are dropped.

Each counter runs a two-state machine: CNT_STOP (holding) and CNT_RUN (counting). The arcs are: start (STOP to RUN while the enable bit is 1, clearing the count) and halt (RUN to STOP once the enable bit is 0, holding the count). Each capture unit runs a two-state machine: CAP_IDLE and CAP_SETTLE. The arcs are: request (IDLE to SETTLE on a capture write with data bit 0 set) and publish (SETTLE to IDLE when the settle counter is exhausted, copying the shadow to the snapshot).

Top module: `mct_timer`

## Requirements
- R1: After reset every counter is stopped at 0. The enable, mode, match, preload, interrupt-enable, pending and snapshot registers all read 0, and every irq bit is low.
- R2: Word address 0 is the enable register, with bit t running timer t. Changing one bit leaves the other timers' counts untouched, so writing 0x6 over 0x7 halts timer 0 only.
- R3: A timer whose enable bit is 0 holds its count. When the bit goes from 0 to 1 the count restarts: it is 0 after the following clock edge.
- R4: A running timer adds 1 on every clock edge and wraps modulo 2^CNT_W. If timer t is enabled at edge W and not reloaded, the count before edge C is (C-W-2) mod 2^CNT_W.
- R5: A timer reloads when its mode bit (word address 1, bit t) is 0 and its preload bit (block offset 4, bit 0) is 1. When the count equals match value 0, the next value is 0, so the period is match0+1 edges.
- R6: With the preload bit at 0, or with the mode bit at 1, the counter never reloads. It counts past match value 0 and simply wraps.
- R7: When a running timer's count equals match value j, pending bit j is set one edge later, whatever the interrupt-enable bits are. Pending bits stay set until they are cleared.
- R8: A write to the status word (block offset 6) clears each pending bit written as 1 and leaves bits written as 0 alone. A match in the same cycle keeps its bit set.
- R9: irq[t] is high in any cycle where some pending bit of timer t has its bit in the interrupt-enable word (block offset 5) set. Writing 0 there masks the line without losing the pending bits.
- R10: A write with bit 0 set to the capture word (block offset 7) latches the count of that cycle. Reads of that word return the previous snapshot until SETTLE edges later, then the new value. A write with bit 0 clear has no effect.
- R11: Status bit 31 is 1 for exactly the SETTLE cycles after a capture request. Capture requests made during that time are ignored.
- R12: Timer t's registers sit at word base 8*(t+1). Offsets 0 to NC-1 are the match values, 4 the preload bit, 5 the interrupt enables, 6 the status word (pending in bits NC-1:0) and 7 the capture word. All of them, plus the enable and mode words, read back what was written, truncated to their width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the current address and data |
| bus_addr | input | ADDR_W | Word address (5 bits by default) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | NT | Level interrupt, one per timer |

## Verification
A write takes effect at the edge that samples it. The count is 0 one edge after the enable edge and n-1 after n more edges. A pending bit is due one edge after the cycle in which the count equals its match value. irq follows the registers in the same cycle. A snapshot becomes readable SETTLE edges after its request edge. The bench counts clock edges and records the index of every write edge. It derives each expected count from those indices with plain modular arithmetic. It reads the bus only at falling edges, so a check lands either one cycle before or exactly on the edge where a result is due, and both sides of each boundary are checked.

// File: rtl/mct_pkg.sv
`timescale 1ns/1ps
package mct_pkg;
    localparam int DATA_W      = 32;
    localparam int BLK_WORDS   = 8;
    localparam int REG_ENABLE  = 0;
    localparam int REG_MODE    = 1;
    localparam int OFS_PRELOAD = 4;
    localparam int OFS_IEN     = 5;
    localparam int OFS_STATUS  = 6;
    localparam int OFS_CAPTURE = 7;
    localparam int BUSY_BIT    = 31;

    typedef enum logic {
        CNT_STOP,
        CNT_RUN
    } cnt_state_e;

    typedef enum logic {
        CAP_IDLE,
        CAP_SETTLE
    } cap_state_e;
endpackage

// File: rtl/mct_counter.sv
`timescale 1ns/1ps
module mct_counter
    import mct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             reload_en,
    input  logic [CNT_W-1:0] reload_at,
    output logic [CNT_W-1:0] count,
    output logic             running
);
    cnt_state_e st_q, st_d;
    logic       at_reload;

    assign at_reload = reload_en && (count == reload_at);
    assign running   = (st_q == CNT_RUN);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CNT_STOP;
        else        st_q <= st_d;
    end

    // transitions: start / halt
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CNT_STOP: if (enable)  st_d = CNT_RUN;
            CNT_RUN:  if (!enable) st_d = CNT_STOP;
        endcase
    end

    // count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case (st_q)
                CNT_STOP: if (enable) count <= '0;
                CNT_RUN:  if (enable) count <= at_reload ? '0 : count + 1'b1;
            endcase
        end
    end

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CNT_STOP && !enable) |=> $stable(count)); // R3
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CNT_STOP && enable) |=> (count == '0)); // R3
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CNT_RUN && enable && reload_en && count == reload_at) |=> (count == '0)); // R5
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CNT_RUN && enable && !(reload_en && count == reload_at))
        |=> (count == CNT_W'($past(count) + 1'b1))); // R4
endmodule

// File: rtl/mct_match.sv
`timescale 1ns/1ps
module mct_match
    import mct_pkg::*;
#(
    parameter int NC    = 3,
    parameter int CNT_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     running,
    input  logic [CNT_W-1:0]         count,
    input  logic [NC-1:0][CNT_W-1:0] match_val,
    input  logic                     clr_we,
    input  logic [NC-1:0]            clr_mask,
    input  logic [NC-1:0]            ien,
    output logic [NC-1:0]            pend,
    output logic                     irq
);
    logic [NC-1:0] hit;
    logic [NC-1:0] clr_eff;

    for (genvar j = 0; j < NC; j++) begin : g_cmp
        assign hit[j] = running && (count == match_val[j]);
    end

    assign clr_eff = clr_we ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_eff) | hit;
    end

    assign irq = |(pend & ien);

    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> ((pend & $past(hit)) == $past(hit))); // R7
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we) |=> ((pend & $past(pend)) == $past(pend))); // R7
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((pend & $past(clr_mask & ~hit)) == '0)); // R8
    AST_CLEAR_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((pend & $past(pend & ~clr_mask)) == $past(pend & ~clr_mask))); // R8
endmodule

// File: rtl/mct_capture.sv
`timescale 1ns/1ps
module mct_capture
    import mct_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int SETTLE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] snap,
    output logic             busy
);
    localparam int RW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
    localparam int LW = $clog2(SETTLE + 2);

    cap_state_e       st_q, st_d;
    logic [RW-1:0]    remain_q;
    logic [CNT_W-1:0] shadow_q;

    assign busy = (st_q == CAP_SETTLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CAP_IDLE;
        else        st_q <= st_d;
    end

    // transitions: request / publish
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CAP_IDLE:   if (start)           st_d = CAP_SETTLE;
            CAP_SETTLE: if (remain_q == '0)  st_d = CAP_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            shadow_q <= '0;
            snap     <= '0;
        end else begin
            unique case (st_q)
                CAP_IDLE: begin
                    if (start) begin
                        shadow_q <= count;
                        remain_q <= RW'(SETTLE - 1);
                    end
                end
                CAP_SETTLE: begin
                    if (remain_q == '0) snap <= shadow_q;
                    else                remain_q <= remain_q - 1'b1;
                end
            endcase
        end
    end

    // window counter for the busy-length checks
    logic [LW-1:0] busy_len;
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && remain_q != '0) |=> $stable(snap)); // R10
    AST_IDLE_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy) |=> $stable(snap)); // R10
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(shadow_q)); // R11
    AST_SETTLE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len <= LW'(SETTLE)); // R11
    AST_SETTLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && busy_len == LW'(SETTLE - 1)) |=> !busy); // R11
endmodule

// File: rtl/mct_timer.sv
`timescale 1ns/1ps
module mct_timer
    import mct_pkg::*;
#(
    parameter int NT     = 3,
    parameter int NC     = 3,
    parameter int CNT_W  = 32,
    parameter int SETTLE = 4,
    localparam int ADDR_W = $clog2((NT + 1) * BLK_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NT-1:0]     irq
);
    localparam int OFS_W = $clog2(BLK_WORDS);
    localparam int BLK_W = ADDR_W - OFS_W;

    logic [BLK_W-1:0] blk;
    logic [OFS_W-1:0] ofs;
    logic [NT-1:0]    en_q;
    logic [NT-1:0]    mode_q;
    logic [DATA_W-1:0] blk_rd [NT];

    assign blk = bus_addr[ADDR_W-1:OFS_W];
    assign ofs = bus_addr[OFS_W-1:0];

    // global control words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= '0;
        end else if (bus_we && blk == '0) begin
            if (ofs == OFS_W'(REG_ENABLE)) en_q   <= bus_wdata[NT-1:0];
            if (ofs == OFS_W'(REG_MODE))   mode_q <= bus_wdata[NT-1:0];
        end
    end

    for (genvar t = 0; t < NT; t++) begin : g_tmr
        logic                     sel;
        logic [NC-1:0][CNT_W-1:0] mval_q;
        logic                     preload_q;
        logic [NC-1:0]            ien_q;
        logic [CNT_W-1:0]         count;
        logic                     running;
        logic [NC-1:0]            pend;
        logic [CNT_W-1:0]         snap;
        logic                     busy;
        logic [DATA_W-1:0]        status;

        assign sel = bus_we && (int'(blk) == t + 1);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mval_q    <= '0;
                preload_q <= 1'b0;
                ien_q     <= '0;
            end else if (sel) begin
                for (int j = 0; j < NC; j++) begin
                    if (int'(ofs) == j) mval_q[j] <= bus_wdata[CNT_W-1:0];
                end
                if (ofs == OFS_W'(OFS_PRELOAD)) preload_q <= bus_wdata[0];
                if (ofs == OFS_W'(OFS_IEN))     ien_q     <= bus_wdata[NC-1:0];
            end
        end

        mct_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .enable    (en_q[t]),
            .reload_en (preload_q && !mode_q[t]),
            .reload_at (mval_q[0]),
            .count     (count),
            .running   (running)
        );

        mct_match #(.NC(NC), .CNT_W(CNT_W)) u_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .running   (running),
            .count     (count),
            .match_val (mval_q),
            .clr_we    (sel && ofs == OFS_W'(OFS_STATUS)),
            .clr_mask  (bus_wdata[NC-1:0]),
            .ien       (ien_q),
            .pend      (pend),
            .irq       (irq[t])
        );

        mct_capture #(.CNT_W(CNT_W), .SETTLE(SETTLE)) u_cap (
            .clk   (clk),
            .rst_n (rst_n),
            .start (sel && ofs == OFS_W'(OFS_CAPTURE) && bus_wdata[0]),
            .count (count),
            .snap  (snap),
            .busy  (busy)
        );

        always_comb begin
            status           = '0;
            status[NC-1:0]   = pend;
            status[BUSY_BIT] = busy;
        end

        always_comb begin
            blk_rd[t] = '0;
            for (int j = 0; j < NC; j++) begin
                if (int'(ofs) == j) blk_rd[t] = DATA_W'(mval_q[j]);
            end
            if (ofs == OFS_W'(OFS_PRELOAD)) blk_rd[t] = DATA_W'(preload_q);
            if (ofs == OFS_W'(OFS_IEN))     blk_rd[t] = DATA_W'(ien_q);
            if (ofs == OFS_W'(OFS_STATUS))  blk_rd[t] = status;
            if (ofs == OFS_W'(OFS_CAPTURE)) blk_rd[t] = DATA_W'(snap);
        end

        AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            (ien_q == '0) |-> !irq[t]); // R9
        AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            irq[t] |-> (pend != '0)); // R9
    end

    always_comb begin
        bus_rdata = '0;
        if (blk == '0) begin
            if (ofs == OFS_W'(REG_ENABLE)) bus_rdata = DATA_W'(en_q);
            if (ofs == OFS_W'(REG_MODE))   bus_rdata = DATA_W'(mode_q);
        end else begin
            for (int i = 0; i < NT; i++) begin
                if (int'(blk) == i + 1) bus_rdata = blk_rd[i];
            end
        end
    end
endmodule

// File: tb/mct_timer_test.sv
`timescale 1ns/1ps
module mct_timer_test;
    localparam int NT = 3;
    localparam int NC = 3;
    localparam int CW = 8;
    localparam int ST = 4;
    localparam int WRAP = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          we = 1'b0;
    logic [4:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NT-1:0] irq;

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    int last_edge = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mct_timer #(.NT(NT), .NC(NC), .CNT_W(CW), .SETTLE(ST)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    function automatic logic [4:0] ta(int t, int o);
        return 5'((t + 1) * 8 + o);
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk);
        #1 last_edge = cyc;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // capture timer t and compare with an expected value
    task automatic cap_exp(int t, int expv, string req);
        logic [31:0] d;
        wr(ta(t, 7), 32'h1);
        rd(ta(t, 6), d);
        check("R11", "busy after request", 32'(d[31]), 32'h1);
        idle(ST);
        rd(ta(t, 6), d);
        check("R11", "busy cleared", 32'(d[31]), 32'h0);
        rd(ta(t, 7), d);
        check(req, "captured count", d, 32'(expv));
    endtask

    // capture timer t enabled at edge w, modulus m
    task automatic cap_mod(int t, int w, int m, string req);
        logic [31:0] d;
        int expv;
        wr(ta(t, 7), 32'h1);
        expv = (last_edge - w - 2) % m;
        idle(ST);
        rd(ta(t, 7), d);
        check(req, "captured count", d, 32'(expv));
    endtask

    initial begin
        repeat (2000 * 100) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL all watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int w, w2, s, frozen, c1, c2, a, b;
        int m_hit;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(5'd0, d); check("R1", "enable", d, 0);
        rd(5'd1, d); check("R1", "mode", d, 0);
        check("R1", "irq", 32'(irq), 0);
        for (int t = 0; t < NT; t++) begin
            rd(ta(t, 6), d); check("R1", "status", d, 0);
            rd(ta(t, 7), d); check("R1", "snapshot", d, 0);
            rd(ta(t, 0), d); check("R1", "match0", d, 0);
        end

        // R12 register map readback sweep
        for (int t = 0; t < NT; t++) begin
            for (int j = 0; j < NC; j++) begin
                wr(ta(t, j), 32'hA5A5_0000 | 32'(t * 16 + j + 40));
                rd(ta(t, j), d);
                check("R12", "match readback", d, 32'((t * 16 + j + 40) % WRAP));
            end
            wr(ta(t, 4), 32'hFFFF_FFFF); rd(ta(t, 4), d); check("R12", "preload readback", d, 1);
            wr(ta(t, 4), 0);
            wr(ta(t, 5), 32'hFF); rd(ta(t, 5), d); check("R12", "ien readback", d, 7);
            wr(ta(t, 5), 0);
        end
        wr(5'd1, 32'h5); rd(5'd1, d); check("R12", "mode readback", d, 5);
        wr(5'd1, 32'h0);

        // R4 / R6 free-running sweep across wrap
        wr(5'd0, 32'h7); w = last_edge;
        idle(1);
        for (int k = 0; k < 60; k++) begin
            cap_mod(k % NT, w, WRAP, "R4");
            idle(k % 5);
        end

        // R2 / R3 stop one timer, others keep running, restart from zero
        wr(5'd0, 32'h6); s = last_edge;
        frozen = (s - w - 1) % WRAP;
        idle(3);
        cap_exp(0, frozen, "R3");
        idle(20);
        cap_exp(0, frozen, "R3");
        cap_mod(1, w, WRAP, "R2");
        cap_mod(2, w, WRAP, "R2");
        rd(5'd0, d); check("R2", "enable word", d, 6);
        wr(5'd0, 32'h7); w2 = last_edge;
        idle(2);
        cap_mod(0, w2, WRAP, "R3");
        cap_mod(1, w, WRAP, "R2");

        // R5 periodic sweep over match0
        wr(5'd0, 32'h0);
        for (int m = 1; m <= 24; m++) begin
            int t;
            t = m % NT;
            wr(ta(t, 0), 32'(m));
            wr(ta(t, 4), 32'h1);
            wr(5'd0, 32'(1 << t)); w = last_edge;
            idle(1);
            for (int k = 0; k < 3; k++) begin
                cap_mod(t, w, m + 1, "R5");
                idle(m % 4);
            end
            wr(5'd0, 32'h0);
            wr(ta(t, 4), 32'h0);
        end

        // R6 mode bit overrides preload
        wr(ta(1, 0), 32'd5);
        wr(ta(1, 4), 32'h1);
        wr(5'd1, 32'h2);
        wr(5'd0, 32'h2); w = last_edge;
        idle(10);
        cap_mod(1, w, WRAP, "R6");
        cap_mod(1, w, WRAP, "R6");
        wr(5'd0, 32'h0); wr(5'd1, 32'h0); wr(ta(1, 4), 32'h0);

        // R7 / R8 / R9 match, status, interrupt
        m_hit = 20;
        wr(ta(2, 0), 32'd200);
        wr(ta(2, 1), 32'(m_hit));
        wr(ta(2, 2), 32'd250);
        wr(ta(2, 5), 32'h0);
        wr(ta(2, 6), 32'h7);
        rd(ta(2, 6), d); check("R8", "cleared all", d, 0);
        wr(5'd0, 32'h4);
        idle(m_hit + 1);
        rd(ta(2, 6), d); check("R7", "pending before due", 32'(d[2:0]), 0);
        idle(1);
        rd(ta(2, 6), d); check("R7", "pending when due", 32'(d[2:0]), 2);
        check("R7", "irq masked while pending", 32'(irq[2]), 0);
        wr(ta(2, 5), 32'h2);
        check("R9", "irq enabled", 32'(irq[2]), 1);
        wr(ta(2, 5), 32'h0);
        check("R9", "irq masked", 32'(irq[2]), 0);
        rd(ta(2, 6), d); check("R9", "pending kept under mask", 32'(d[2:0]), 2);
        wr(ta(2, 5), 32'h2);
        wr(ta(2, 6), 32'h5);
        rd(ta(2, 6), d); check("R8", "zero bits leave pending", 32'(d[2:0]), 2);
        check("R9", "irq still high", 32'(irq[2]), 1);
        wr(ta(2, 6), 32'h2);
        rd(ta(2, 6), d); check("R8", "one bit clears", 32'(d[2:0]), 0);
        check("R9", "irq dropped", 32'(irq[2]), 0);
        wr(5'd0, 32'h0);
        wr(5'd0, 32'h4);
        idle(m_hit + 1);
        wr(ta(2, 6), 32'h2);
        rd(ta(2, 6), d); check("R8", "set wins over clear", 32'(d[2:0]), 2);
        wr(ta(2, 6), 32'h2);
        rd(ta(2, 6), d); check("R8", "later clear", 32'(d[2:0]), 0);
        wr(5'd0, 32'h0);
        wr(ta(2, 5), 32'h0);

        // R10 / R11 capture settling and busy
        wr(5'd0, 32'h2); w = last_edge;
        idle(5);
        wr(ta(1, 7), 32'h1); c1 = last_edge;
        a = (c1 - w - 2) % WRAP;
        idle(ST);
        rd(ta(1, 7), d); check("R10", "first snapshot", d, 32'(a));
        idle(3);
        wr(ta(1, 7), 32'h1); c2 = last_edge;
        b = (c2 - w - 2) % WRAP;
        rd(ta(1, 6), d); check("R11", "busy flag set", 32'(d[31]), 1);
        rd(ta(1, 7), d); check("R10", "old snapshot while settling", d, 32'(a));
        wr(ta(1, 7), 32'h1);
        rd(ta(1, 6), d); check("R11", "still busy", 32'(d[31]), 1);
        idle(ST - 2);
        rd(ta(1, 7), d); check("R10", "old snapshot last busy cycle", d, 32'(a));
        rd(ta(1, 6), d); check("R11", "busy last cycle", 32'(d[31]), 1);
        idle(1);
        rd(ta(1, 7), d); check("R11", "second request ignored", d, 32'(b));
        rd(ta(1, 6), d); check("R11", "busy done", 32'(d[31]), 0);
        wr(ta(1, 7), 32'h2);
        rd(ta(1, 6), d); check("R10", "bit0 clear no request", 32'(d[31]), 0);
        idle(ST + 1);
        rd(ta(1, 7), d); check("R10", "snapshot unchanged", d, 32'(b));
        wr(5'd0, 32'h0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule